// File: doc/BRIEF.md
# Wavefront Crossbar Scheduler

This block schedules an N-by-N cell switch. In every cycle it takes a request matrix in which bit `i*N + j` of `req_matrix` means that input `i` holds a cell for output `j`. From that matrix it produces a grant matrix in the same layout. In the grant matrix every input is paired with at most one output and every output with at most one input. The decision comes from one feed-forward sweep over the wrapped diagonals of the matrix, with no iteration.

The wrapped diagonal of cell `(i, j)` is `(j - i) mod N`. The N cells on one diagonal never share a row or a column, so one diagonal is settled as a single step. The sweep begins at a start diagonal held in a rotation register and visits the diagonals in rising order modulo N. A cell wins when it has a request and no earlier diagonal has already taken its row or its column. The start diagonal moves forward by one each cycle, so the priority among inputs is reshuffled all the time and no input keeps a standing advantage. The grant matrix and its valid flag are registered, so a decision appears one cycle after the request that produced it.

Top module: `wfa_sched`

## Requirements
- R1: While `rst_n` is low, `grant_valid` is 0 and `grant_matrix` is all zeros.
- R2: A grant matrix never has more than one bit set within a row `i` (bits `i*N .. i*N+N-1`).
- R3: A grant matrix never has more than one bit set within a column `j` (bits `j, N+j, 2N+j, ...`).
- R4: A grant bit is set only where the request that produced it had the same bit set.
- R5: The match is maximal. For every requested pair `(i, j)`, row `i` or column `j` carries a grant.
- R6: `grant_valid` equals the `req_valid` of the previous clock cycle, and the grants for a request sampled at one edge appear after that edge.
- R7: A request matrix sampled while `req_valid` is low has no effect. The next `grant_matrix` is all zeros.
- R8: An all-zero request matrix sampled with `req_valid` high yields an all-zero grant matrix with `grant_valid` high.
- R9: The start diagonal is 0 at the first edge after reset and rises by one, modulo N, at every clock edge after that, whether or not `req_valid` is high. Diagonals are taken in the order start, start+1, ... modulo N. Cell `(i, j)` lies on diagonal `(j - i) mod N` and wins if it has a request and its row and column are still free.
- R10: With every request bit set, the grants form the full permutation `j = (i + start) mod N`. This permutation shifts by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Qualifies `req_matrix` in this cycle |
| req_matrix | input | N*N | Request bits, bit `i*N+j` = input i wants output j |
| grant_valid | output | 1 | Registered copy of `req_valid` |
| grant_matrix | output | N*N | Registered grants, same layout as the requests |

## Verification
Every result of this block is due exactly one clock edge after the request that produced it. The start diagonal used for that request is the number of edges since reset, modulo N. The bench applies each request at a falling edge and reads `grant_valid` and `grant_matrix` at the next falling edge. It keeps its own count of rising edges since reset and uses that count to work out the diagonal order it expects. This keeps every comparison half a cycle away from the edge that updates the outputs, for both the directed and the random patterns.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

  // Adds two indices and wraps the result into the range 0 .. n-1.
  function automatic int wrap_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction

  // Index of cell (row, col) in a flattened N*N matrix.
  function automatic int cell_idx(input int row, input int col, input int n);
    return row * n + col;
  endfunction

endpackage

// File: rtl/wfa_rotor.sv
module wfa_rotor #(
  parameter int N  = 4,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [RW-1:0] rot_q,
  output logic          rot_wrap
);
  localparam logic [RW-1:0] LAST = RW'(N - 1);

  assign rot_wrap = (rot_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rot_q <= '0;
    else if (rot_wrap) rot_q <= '0;
    else               rot_q <= rot_q + RW'(1);
  end
endmodule

// File: rtl/wfa_colrot.sv
module wfa_colrot #(
  parameter int N     = 4,
  parameter int RW    = 2,
  parameter bit UNDO  = 1'b0
) (
  input  logic [N*N-1:0] din,
  input  logic [RW-1:0]  rot,
  output logic [N*N-1:0] dout
);
  import wfa_pkg::*;

  generate
    if (UNDO) begin : g_undo
      // rotated column c goes back to physical column (c + rot) mod N
      always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
          for (int c = 0; c < N; c++) begin
            dout[cell_idx(i, wrap_add(c, int'(rot), N), N)] = din[cell_idx(i, c, N)];
          end
        end
      end
    end else begin : g_fwd
      // rotated column c reads physical column (c + rot) mod N
      always_comb begin
        for (int i = 0; i < N; i++) begin
          for (int c = 0; c < N; c++) begin
            dout[cell_idx(i, c, N)] = din[cell_idx(i, wrap_add(c, int'(rot), N), N)];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wfa_wave.sv
module wfa_wave #(
  parameter int N = 4
) (
  input  logic [N*N-1:0] req_rot,
  output logic [N*N-1:0] gnt_rot
);
  import wfa_pkg::*;

  logic [N-1:0] row_free;
  logic [N-1:0] col_free;

  // Step s covers cells (i, (i+s) mod N): one cell per row and per column.
  always_comb begin
    row_free = '1;
    col_free = '1;
    gnt_rot  = '0;
    for (int s = 0; s < N; s++) begin
      for (int i = 0; i < N; i++) begin
        int c;
        c = wrap_add(i, s, N);
        if (req_rot[cell_idx(i, c, N)] && row_free[i] && col_free[c]) begin
          gnt_rot[cell_idx(i, c, N)] = 1'b1;
          row_free[i] = 1'b0;
          col_free[c] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wfa_sched.sv
module wfa_sched #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [N*N-1:0] req_matrix,
  output logic           grant_valid,
  output logic [N*N-1:0] grant_matrix
);
  localparam int NN = N * N;
  localparam int RW = (N > 1) ? $clog2(N) : 1;

  logic [RW-1:0] rot_q;
  logic          rot_wrap;
  logic [NN-1:0] req_rot;
  logic [NN-1:0] gnt_rot;
  logic [NN-1:0] gnt_next;

  wfa_rotor #(.N(N), .RW(RW)) rotor_i (
    .clk(clk), .rst_n(rst_n), .rot_q(rot_q), .rot_wrap(rot_wrap)
  );

  wfa_colrot #(.N(N), .RW(RW), .UNDO(1'b0)) fwd_i (
    .din(req_matrix), .rot(rot_q), .dout(req_rot)
  );

  wfa_wave #(.N(N)) wave_i (
    .req_rot(req_rot), .gnt_rot(gnt_rot)
  );

  wfa_colrot #(.N(N), .RW(RW), .UNDO(1'b1)) back_i (
    .din(gnt_rot), .rot(rot_q), .dout(gnt_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid  <= 1'b0;
      grant_matrix <= '0;
    end else begin
      grant_valid  <= req_valid;
      grant_matrix <= req_valid ? gnt_next : '0;
    end
  end
endmodule

// File: rtl/wfa_sched_chk.sv
module wfa_sched_chk #(
  parameter int N  = 4,
  parameter int RW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [N*N-1:0] req_matrix,
  input logic           grant_valid,
  input logic [N*N-1:0] grant_matrix,
  input logic [RW-1:0]  rot_q
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  function automatic bit rows_ok(input logic [N*N-1:0] g);
    for (int i = 0; i < N; i++) begin
      int k;
      k = 0;
      for (int j = 0; j < N; j++) k += int'(g[i*N+j]);
      if (k > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit cols_ok(input logic [N*N-1:0] g);
    for (int j = 0; j < N; j++) begin
      int k;
      k = 0;
      for (int i = 0; i < N; i++) k += int'(g[i*N+j]);
      if (k > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit maximal(input logic [N*N-1:0] r, input logic [N*N-1:0] g);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (r[i*N+j]) begin
          bit hit;
          hit = 1'b0;
          for (int k = 0; k < N; k++) hit = hit | g[i*N+k] | g[k*N+j];
          if (!hit) return 1'b0;
        end
      end
    end
    return 1'b1;
  endfunction

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!grant_valid && grant_matrix == '0));

  // R2
  row_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rows_ok(grant_matrix));

  // R3
  col_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cols_ok(grant_matrix));

  // R4
  grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> ((grant_matrix & ~$past(req_matrix)) == '0));

  // R5
  maximal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && req_valid) |=> maximal($past(req_matrix), grant_matrix));

  // R6
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> (grant_valid == $past(req_valid)));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !req_valid) |=> (grant_matrix == '0));

  // R9
  rot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> (int'(rot_q) == (int'($past(rot_q)) + 1) % N));
endmodule

bind wfa_sched wfa_sched_chk #(.N(N), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_matrix(req_matrix),
  .grant_valid(grant_valid), .grant_matrix(grant_matrix), .rot_q(rot_q)
);

// File: tb/wfa_sched_tb.sv
`timescale 1ns/1ps
module wfa_sched_tb_top;
  localparam int N  = 4;
  localparam int NN = N * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [NN-1:0] req_matrix = '0;
  logic          grant_valid;
  logic [NN-1:0] grant_matrix;

  int checks = 0;
  int failures = 0;
  int start_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wfa_sched #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_matrix(req_matrix),
    .grant_valid(grant_valid), .grant_matrix(grant_matrix)
  );

  // R9: start diagonal counted independently as edges since reset
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_cnt <= 0;
    else        start_cnt <= (start_cnt + 1) % N;
  end

  function automatic logic [NN-1:0] model(input logic [NN-1:0] r, input int st);
    logic [NN-1:0] g;
    bit rtak [N];
    bit ctak [N];
    g = '0;
    for (int k = 0; k < N; k++) begin rtak[k] = 0; ctak[k] = 0; end
    for (int d = 0; d < N; d++) begin
      int diag;
      diag = (st + d) % N;
      for (int i = 0; i < N; i++) begin
        int j;
        j = (i + diag) % N;
        if (r[i*N+j] && !rtak[i] && !ctak[j]) begin
          g[i*N+j] = 1'b1; rtak[i] = 1; ctak[j] = 1;
        end
      end
    end
    return g;
  endfunction

  function automatic bit one_per_row(input logic [NN-1:0] g);
    for (int i = 0; i < N; i++) if ($countones(g[i*N +: N]) > 1) return 0;
    return 1;
  endfunction

  function automatic bit one_per_col(input logic [NN-1:0] g);
    for (int j = 0; j < N; j++) begin
      int k;
      k = 0;
      for (int i = 0; i < N; i++) k += int'(g[i*N+j]);
      if (k > 1) return 0;
    end
    return 1;
  endfunction

  function automatic bit is_maximal(input logic [NN-1:0] r, input logic [NN-1:0] g);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (r[i*N+j]) begin
          bit hit;
          hit = 0;
          for (int k = 0; k < N; k++) hit = hit | g[i*N+k] | g[k*N+j];
          if (!hit) return 0;
        end
    return 1;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [NN-1:0] act, input logic [NN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, evaluate at the following negedge
  task automatic apply(input bit v, input logic [NN-1:0] r, input string tag);
    logic [NN-1:0] exp;
    exp = v ? model(r, start_cnt) : '0;
    req_valid  = v;
    req_matrix = r;
    @(posedge clk);
    @(negedge clk);
    check({"R6 ", tag}, grant_valid == v, NN'(grant_valid), NN'(v));
    check({"R9 ", tag}, grant_matrix == exp, grant_matrix, exp);
    check("R2 row", one_per_row(grant_matrix), grant_matrix, exp);
    check("R3 col", one_per_col(grant_matrix), grant_matrix, exp);
    check("R4 subset", (grant_matrix & ~r) == '0, grant_matrix, exp);
    if (v) check("R5 maximal", is_maximal(r, grant_matrix), grant_matrix, exp);
  endtask

  initial begin
    #40000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 reset valid", grant_valid == 1'b0, NN'(grant_valid), '0);
    check("R1 reset grants", grant_matrix == '0, grant_matrix, '0);
    rst_n = 1'b1;

    // R8: empty request
    apply(1'b1, '0, "R8 zero");
    check("R8 zero grants", grant_matrix == '0, grant_matrix, '0);
    // R7: invalid request ignored
    apply(1'b0, '1, "R7 idle");
    check("R7 idle grants", grant_matrix == '0, grant_matrix, '0);
    // R10: full matrix gives rotating permutation
    for (int c = 0; c < N + 1; c++) begin
      logic [NN-1:0] perm;
      int st;
      st = start_cnt;
      perm = '0;
      for (int i = 0; i < N; i++) perm[i*N + (i + st) % N] = 1'b1;
      apply(1'b1, '1, "R10 full");
      check("R10 permutation", grant_matrix == perm, grant_matrix, perm);
    end
    // single requests and one hot rows/columns
    apply(1'b1, NN'(1) << (2*N + 1), "single");
    apply(1'b1, {{(NN-N){1'b0}}, {N{1'b1}}}, "row0 all");
    apply(1'b1, NN'(1) | NN'(1) << N | NN'(1) << (2*N), "col0 three");
    // random mix
    for (int t = 0; t < 400; t++) begin
      logic [NN-1:0] r;
      bit v;
      r = NN'($urandom());
      if (t % 3 == 0) r = r & NN'($urandom());
      v = ($urandom_range(0, 7) != 0);
      apply(v, r, "random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule